// File: doc/BRIEF.md
# Translation Control and Fault Register Block

This block is the software-visible control point of an address-translation unit. A word-addressed register port lets software turn translation on and off, program a configuration word and the page-table base, request TLB invalidations, and ask the unit to stop taking new translations. The block drives enable and stall lines into the translation datapath. It watches a busy input from the datapath so that it only reports the stall as complete once in-flight work has drained.

The datapath reports faults through a valid/type/address strobe. The block records each fault as one bit of an interrupt status word. It routes the faulting address into one of four capture registers, picked by the fault class, and raises an interrupt line. A fault also forces the unit into the stalled condition, which holds until software writes the run code again. Writing ones to the clear word removes status bits. A fault that lands in the same cycle as a clear or a control write takes priority.

Top module: `xlt_ctl_regs`

## Requirements
- R1: After a synchronous active-low reset, every writable register and capture register reads 0, the control word reads 0 (off), and `irq`, `xlat_stall`, `xlat_enable` and the flush outputs are 0.
- R2: Word 1 (byte 0x004, configuration) and word 5 (byte 0x014, page-table base) read back the last value written and drive `cfg_out` and `pt_base`. Word 13 (byte 0x034) always reads the VERSION parameter and ignores writes. Word 2 (status) ignores writes. Words 3 and 4 (flush) read 0, and so does any unassigned word.
- R3: Writing 0x5 to word 0 selects run mode, 0x0 selects off, and 0x7 requests a stall. Any other value is ignored. Word 0 reads 0x0 when off, 0x5 when running, and 0x7 while stalling or stalled.
- R4: After a stall request, `xlat_stall` is 1 from the next cycle. Status word 2 bit 0 reads 1 only in the cycle after `xlat_busy` is seen low, and it stays 1 until run or off is selected.
- R5: A write to word 3 with bit 0 set pulses `flush_all` for exactly one cycle. A write to word 4 with bit 0 set pulses `flush_entry` for one cycle and presents write-data bits 31:12 on `flush_page`. A write with bit 0 clear produces no pulse.
- R6: A fault reported while the unit is not off sets bit `flt_type` of interrupt status word 6 and stalls the unit as in R4. The unit stays stalled until 0x5 is written. Faults reported while off change nothing.
- R7: The fault address is captured by class. Type 0 loads word 9 (0x024). Types 2, 6 and 7 load word 10 (0x028). Types 1, 4 and 5 load word 11 (0x02C). Type 3 loads word 12 (0x030). The other capture words keep their values.
- R8: Writing ones to word 7 (byte 0x01C) clears the matching bits of word 6. `irq` is 1 exactly when any bit of word 6 is 1.
- R9: In one cycle, a fault's status set beats a clear of the same bit, while other bits in the clear still clear. A fault also beats any control write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| xlat_busy | input | 1 | Datapath has translations in flight |
| flt_valid | input | 1 | Fault report strobe |
| flt_type | input | TW | Fault class, 0..7 |
| flt_addr | input | DW | Faulting device address |
| xlat_enable | output | 1 | Translation switched on |
| xlat_stall | output | 1 | Take no new translations |
| cfg_out | output | DW | Configuration word |
| pt_base | output | DW | Page-table base |
| flush_all | output | 1 | One-cycle invalidate-all request |
| flush_entry | output | 1 | One-cycle single-entry invalidate request |
| flush_page | output | DW-12 | Page number for the entry invalidate |
| irq | output | 1 | Fault interrupt |

## Verification
Two collisions are forced from the same clock edge. In the first, a fault of type 2 arrives in the same cycle that software clears bits 1 and 2. The only correct result is a status word of 0x4: bit 1 is gone, bit 2 is set. In the second, a disable write meets a fault. Afterwards the unit must still be enabled and stalled, and the control word must read 0x7. Both are judged by reading the registers at the next falling edge.

// File: rtl/xlt_regs_pkg.sv
// Package: register word indices, control codes, mode encoding and the
// fault-class to capture-register routing shared by the block.
package xlt_regs_pkg;

    localparam int DW         = 32;
    localparam int PAGE_SHIFT = 12;

    // Word indices (byte offset / 4)
    localparam int W_CTRL   = 0;
    localparam int W_CFG    = 1;
    localparam int W_STAT   = 2;
    localparam int W_FLALL  = 3;
    localparam int W_FLENT  = 4;
    localparam int W_PTB    = 5;
    localparam int W_INTST  = 6;
    localparam int W_INTCLR = 7;
    localparam int W_FA0    = 9;   // first of four capture words
    localparam int W_VER    = 13;

    localparam logic [DW-1:0] CODE_OFF   = 32'h0;
    localparam logic [DW-1:0] CODE_RUN   = 32'h5;
    localparam logic [DW-1:0] CODE_BLOCK = 32'h7;

    // Capture slots, in word order starting at W_FA0
    localparam int FA_PAGE = 0;
    localparam int FA_WR   = 1;
    localparam int FA_RD   = 2;
    localparam int FA_DFLT = 3;
    localparam int FA_NUM  = 4;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_DRAIN = 2'd2,
        MODE_HELD  = 2'd3
    } mode_e;

    // Route a fault class to its capture slot.
    function automatic logic [1:0] fault_dest(input logic [2:0] t);
        case (t)
            3'd0:                 fault_dest = 2'(FA_PAGE);
            3'd3:                 fault_dest = 2'(FA_DFLT);
            3'd1, 3'd4, 3'd5:     fault_dest = 2'(FA_RD);
            default:              fault_dest = 2'(FA_WR);
        endcase
    endfunction

endpackage

// File: rtl/xlt_ctrl_fsm.sv
// Mode controller: decodes control-word writes, stalls on request or fault,
// and reports "stalled" only once the datapath has drained.
// Assumes fault_hit is only asserted while the unit is not off.
module xlt_ctrl_fsm
    import xlt_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] ctrl_code,
    input  logic          fault_hit,
    input  logic          xlat_busy,
    output mode_e         mode,
    output logic          active,
    output logic          stall,
    output logic          blocked
);

    mode_e mode_q, mode_d;

    // Next-mode selection; a fault outranks any control write.
    always_comb begin
        mode_d = mode_q;
        if (fault_hit) begin
            mode_d = (mode_q == MODE_HELD) ? MODE_HELD : MODE_DRAIN;
        end else if (ctrl_wr && ctrl_code == CODE_RUN) begin
            mode_d = MODE_RUN;
        end else if (ctrl_wr && ctrl_code == CODE_OFF) begin
            mode_d = MODE_OFF;
        end else if (ctrl_wr && ctrl_code == CODE_BLOCK) begin
            mode_d = (mode_q == MODE_HELD) ? MODE_HELD : MODE_DRAIN;
        end else if (mode_q == MODE_DRAIN && !xlat_busy) begin
            mode_d = MODE_HELD;
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode_d;
    end

    assign mode    = mode_q;
    assign active  = (mode_q != MODE_OFF);
    assign stall   = (mode_q == MODE_DRAIN) || (mode_q == MODE_HELD);
    assign blocked = (mode_q == MODE_HELD);

    p_held_needs_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HELD && $past(mode_q) != MODE_HELD) |-> !$past(xlat_busy));

    p_fault_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> stall);

    p_run_by_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && $past(mode_q) != MODE_RUN)
            |-> $past(ctrl_wr && ctrl_code == CODE_RUN));

endmodule

// File: rtl/xlt_fault_log.sv
// Fault recorder: one sticky status bit per fault class, write-one-to-clear,
// and four address capture registers selected by fault class.
// Assumes hit is already qualified with "unit active". Set beats clear.
module xlt_fault_log
    import xlt_regs_pkg::*;
#(
    parameter int FLT_TYPES = 8,
    localparam int TW = $clog2(FLT_TYPES)
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hit,
    input  logic [TW-1:0]               ftype,
    input  logic [DW-1:0]               faddr,
    input  logic                        clr_wr,
    input  logic [FLT_TYPES-1:0]        clr_mask,
    output logic [FLT_TYPES-1:0]        int_stat,
    output logic [FA_NUM-1:0][DW-1:0]   fa_regs,
    output logic                        irq
);

    logic [FLT_TYPES-1:0] stat_q;
    logic [FLT_TYPES-1:0] set_mask;
    logic [FLT_TYPES-1:0] clr_eff;
    logic [1:0]           dest;

    assign set_mask = hit ? (FLT_TYPES'(1) << ftype) : '0;
    assign clr_eff  = clr_wr ? clr_mask : '0;
    assign dest     = fault_dest(3'(ftype));

    // Status update: clear first, then OR in the new fault.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_eff) | set_mask;
    end

    for (genvar g = 0; g < FA_NUM; g++) begin : g_cap
        logic [DW-1:0] cap_q;
        // Capture slot g: loads the faulting address for its class.
        always_ff @(posedge clk) begin
            if (!rst_n)                         cap_q <= '0;
            else if (hit && dest == 2'(g))      cap_q <= faddr;
        end
        assign fa_regs[g] = cap_q;
    end

    assign int_stat = stat_q;
    assign irq      = |stat_q;

    for (genvar b = 0; b < FLT_TYPES; b++) begin : g_chk
        p_clear_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_wr && clr_mask[b] && !(hit && ftype == TW'(b))) |=> !int_stat[b]);
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> int_stat[$past(ftype)]);

    p_page_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ftype == '0) |=> fa_regs[FA_PAGE] == $past(faddr));

endmodule

// File: rtl/xlt_flush_pulse.sv
// Invalidate request generator: turns a write with bit 0 set into a
// registered single-cycle pulse, and latches the page number for entries.
module xlt_flush_pulse
    import xlt_regs_pkg::*;
#(
    localparam int PW = DW - PAGE_SHIFT
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          all_wr,
    input  logic          ent_wr,
    input  logic          go_bit,
    input  logic [PW-1:0] page_in,
    output logic          flush_all,
    output logic          flush_entry,
    output logic [PW-1:0] flush_page
);

    // Pulse registers; each lasts one cycle per qualifying write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_all   <= 1'b0;
            flush_entry <= 1'b0;
            flush_page  <= '0;
        end else begin
            flush_all   <= all_wr && go_bit;
            flush_entry <= ent_wr && go_bit;
            if (ent_wr && go_bit) flush_page <= page_in;
        end
    end

    p_all_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |-> $past(all_wr && go_bit));

    p_entry_from_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush_entry |-> $past(ent_wr && go_bit));

endmodule

// File: rtl/xlt_ctl_regs.sv
// Top: word-addressed register file for an address-translation unit.
// Decodes writes, holds configuration and table base, and combines the mode
// controller, fault recorder and flush generator. Reads are combinational.
module xlt_ctl_regs
    import xlt_regs_pkg::*;
#(
    parameter int            ADDR_W    = 6,
    parameter int            FLT_TYPES = 8,
    parameter logic [31:0]   VERSION   = 32'h3000_0001,
    localparam int           TW        = $clog2(FLT_TYPES),
    localparam int           PW        = DW - PAGE_SHIFT
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              xlat_busy,
    input  logic              flt_valid,
    input  logic [TW-1:0]     flt_type,
    input  logic [DW-1:0]     flt_addr,
    output logic              xlat_enable,
    output logic              xlat_stall,
    output logic [DW-1:0]     cfg_out,
    output logic [DW-1:0]     pt_base,
    output logic              flush_all,
    output logic              flush_entry,
    output logic [PW-1:0]     flush_page,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(W_CTRL);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(W_CFG);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(W_STAT);
    localparam logic [ADDR_W-1:0] A_FLALL  = ADDR_W'(W_FLALL);
    localparam logic [ADDR_W-1:0] A_FLENT  = ADDR_W'(W_FLENT);
    localparam logic [ADDR_W-1:0] A_PTB    = ADDR_W'(W_PTB);
    localparam logic [ADDR_W-1:0] A_INTST  = ADDR_W'(W_INTST);
    localparam logic [ADDR_W-1:0] A_INTCLR = ADDR_W'(W_INTCLR);
    localparam logic [ADDR_W-1:0] A_VER    = ADDR_W'(W_VER);

    mode_e                      mode;
    logic                       active, stall, blocked, fault_hit;
    logic [FLT_TYPES-1:0]       int_stat;
    logic [FA_NUM-1:0][DW-1:0]  fa_regs;
    logic [DW-1:0]              cfg_q, ptb_q, ctrl_rd;

    assign fault_hit = flt_valid && active;

    // Plain read/write words: configuration and page-table base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ptb_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CFG) cfg_q <= bus_wdata;
            if (bus_addr == A_PTB) ptb_q <= bus_wdata;
        end
    end

    xlt_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (bus_wr && bus_addr == A_CTRL),
        .ctrl_code (bus_wdata),
        .fault_hit (fault_hit),
        .xlat_busy (xlat_busy),
        .mode      (mode),
        .active    (active),
        .stall     (stall),
        .blocked   (blocked)
    );

    xlt_fault_log #(.FLT_TYPES(FLT_TYPES)) u_flog (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (fault_hit),
        .ftype    (flt_type),
        .faddr    (flt_addr),
        .clr_wr   (bus_wr && bus_addr == A_INTCLR),
        .clr_mask (bus_wdata[FLT_TYPES-1:0]),
        .int_stat (int_stat),
        .fa_regs  (fa_regs),
        .irq      (irq)
    );

    xlt_flush_pulse u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .all_wr      (bus_wr && bus_addr == A_FLALL),
        .ent_wr      (bus_wr && bus_addr == A_FLENT),
        .go_bit      (bus_wdata[0]),
        .page_in     (bus_wdata[DW-1:PAGE_SHIFT]),
        .flush_all   (flush_all),
        .flush_entry (flush_entry),
        .flush_page  (flush_page)
    );

    // Control word readback from the current mode.
    always_comb begin
        case (mode)
            MODE_OFF: ctrl_rd = CODE_OFF;
            MODE_RUN: ctrl_rd = CODE_RUN;
            default:  ctrl_rd = CODE_BLOCK;
        endcase
    end

    // Read multiplexer; unassigned and write-only words read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_rd;
            A_CFG:   bus_rdata = cfg_q;
            A_STAT:  bus_rdata = DW'(blocked);
            A_PTB:   bus_rdata = ptb_q;
            A_INTST: bus_rdata = DW'(int_stat);
            A_VER:   bus_rdata = VERSION;
            default: begin
                for (int k = 0; k < FA_NUM; k++) begin
                    if (bus_addr == ADDR_W'(W_FA0 + k)) bus_rdata = fa_regs[k];
                end
            end
        endcase
    end

    assign xlat_enable = active;
    assign xlat_stall  = stall;
    assign cfg_out     = cfg_q;
    assign pt_base     = ptb_q;

    p_irq_follows_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> irq);

    p_off_ignores_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && flt_valid && !bus_wr) |=> $stable(int_stat));

endmodule

// File: tb/xlt_ctl_regs_tb.sv
`timescale 1ns/1ps
module xlt_ctl_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        xlat_busy = 1'b0;
    logic        flt_valid = 1'b0;
    logic [2:0]  flt_type = '0;
    logic [31:0] flt_addr = '0;
    logic        xlat_enable, xlat_stall, flush_all, flush_entry, irq;
    logic [31:0] cfg_out, pt_base;
    logic [19:0] flush_page;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    xlt_ctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xlat_busy(xlat_busy),
        .flt_valid(flt_valid), .flt_type(flt_type), .flt_addr(flt_addr),
        .xlat_enable(xlat_enable), .xlat_stall(xlat_stall), .cfg_out(cfg_out),
        .pt_base(pt_base), .flush_all(flush_all), .flush_entry(flush_entry),
        .flush_page(flush_page), .irq(irq)
    );

    // Vector: {op(0 write, 1 read-check), word, data, unused}
    localparam int NV = 20;
    localparam logic [43:0] TBL [NV] = '{
        {2'd1, 6'd13, 32'h3000_0001, 4'd0},   // R1 version
        {2'd1, 6'd0,  32'h0000_0000, 4'd0},   // R1 ctrl off
        {2'd0, 6'd1,  32'hA5A5_0001, 4'd0},
        {2'd1, 6'd1,  32'hA5A5_0001, 4'd0},   // R2 cfg
        {2'd0, 6'd5,  32'h8000_4000, 4'd0},
        {2'd1, 6'd5,  32'h8000_4000, 4'd0},   // R2 table base
        {2'd0, 6'd2,  32'hFFFF_FFFF, 4'd0},
        {2'd1, 6'd2,  32'h0000_0000, 4'd0},   // R2 status read-only
        {2'd1, 6'd8,  32'h0000_0000, 4'd0},   // R2 unassigned
        {2'd0, 6'd13, 32'h0000_1234, 4'd0},
        {2'd1, 6'd13, 32'h3000_0001, 4'd0},   // R2 version read-only
        {2'd1, 6'd3,  32'h0000_0000, 4'd0},   // R2 flush word reads 0
        {2'd0, 6'd0,  32'h0000_0005, 4'd0},
        {2'd1, 6'd0,  32'h0000_0005, 4'd0},   // R3 run
        {2'd0, 6'd0,  32'h0000_0003, 4'd0},
        {2'd1, 6'd0,  32'h0000_0005, 4'd0},   // R3 bad code ignored
        {2'd0, 6'd0,  32'h0000_0000, 4'd0},
        {2'd1, 6'd0,  32'h0000_0000, 4'd0},   // R3 off
        {2'd0, 6'd0,  32'h0000_0005, 4'd0},
        {2'd1, 6'd0,  32'h0000_0005, 4'd0}    // R3 run again
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic fault(input logic [2:0] t, input logic [31:0] a);
        @(negedge clk);
        flt_valid = 1'b1; flt_type = t; flt_addr = a;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    function automatic logic [5:0] exp_word(input logic [2:0] t);
        case (t)
            3'd0:             return 6'd9;
            3'd3:             return 6'd12;
            3'd1, 3'd4, 3'd5: return 6'd11;
            default:          return 6'd10;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        check("R1 stall", 32'(xlat_stall), 0);
        check("R1 enable", 32'(xlat_enable), 0);
        check("R1 flush", 32'({flush_all, flush_entry}), 0);
        rd_chk("R1 intstat", 6'd6, 0);
        rd_chk("R1 fa page", 6'd9, 0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i][43:42] == 2'd0) wr(TBL[i][41:36], TBL[i][35:4]);
            else rd_chk($sformatf("R1/R2/R3 vector %0d", i), TBL[i][41:36], TBL[i][35:4]);
        end
        check("R2 cfg_out", cfg_out, 32'hA5A5_0001);
        check("R2 pt_base", pt_base, 32'h8000_4000);
        check("R3 enable", 32'(xlat_enable), 1);

        // R4 stall handshake
        xlat_busy = 1'b1;
        wr(6'd0, 32'h7);
        check("R4 stall next cycle", 32'(xlat_stall), 1);
        rd_chk("R4 status while busy", 6'd2, 0);
        rd_chk("R3 ctrl reads block", 6'd0, 7);
        repeat (3) @(negedge clk);
        rd_chk("R4 status still busy", 6'd2, 0);
        xlat_busy = 1'b0;
        @(negedge clk);
        rd_chk("R4 status after idle", 6'd2, 1);
        wr(6'd0, 32'h5);
        rd_chk("R4 status after run", 6'd2, 0);
        check("R4 stall after run", 32'(xlat_stall), 0);

        // R5 flush pulses
        wr(6'd3, 32'h1);
        check("R5 flush_all pulse", 32'(flush_all), 1);
        @(negedge clk);
        check("R5 flush_all one cycle", 32'(flush_all), 0);
        wr(6'd3, 32'h0);
        check("R5 flush_all no go bit", 32'(flush_all), 0);
        wr(6'd4, 32'h1234_5001);
        check("R5 flush_entry pulse", 32'(flush_entry), 1);
        check("R5 flush_page", 32'(flush_page), 32'h12345);
        @(negedge clk);
        check("R5 flush_entry one cycle", 32'(flush_entry), 0);

        // R6, R7, R8 each fault class
        for (int t = 0; t < 8; t++) begin
            logic [31:0] fa;
            fa = 32'h1000_0000 + 32'(t) * 32'h10;
            fault(3'(t), fa);
            rd_chk($sformatf("R6 status bit type %0d", t), 6'd6, 32'(1) << t);
            check("R8 irq set", 32'(irq), 1);
            check("R6 stall on fault", 32'(xlat_stall), 1);
            rd_chk($sformatf("R7 capture type %0d", t), exp_word(3'(t)), fa);
            @(negedge clk);
            rd_chk("R6 held after fault", 6'd2, 1);
            wr(6'd7, 32'(1) << t);
            rd_chk("R8 cleared", 6'd6, 0);
            check("R8 irq clear", 32'(irq), 0);
            rd_chk("R6 still held until run", 6'd2, 1);
            wr(6'd0, 32'h5);
            check("R6 released by run", 32'(xlat_stall), 0);
        end
        rd_chk("R7 page capture kept", 6'd9, 32'h1000_0000);

        // R6 faults ignored while off
        wr(6'd0, 32'h0);
        fault(3'd0, 32'hDEAD_0000);
        rd_chk("R6 off intstat", 6'd6, 0);
        rd_chk("R6 off capture", 6'd9, 32'h1000_0000);
        check("R6 off stall", 32'(xlat_stall), 0);
        wr(6'd0, 32'h5);

        // R9 set beats clear, other cleared bits still clear
        fault(3'd1, 32'h2000_0000);
        wr(6'd0, 32'h5);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'd7; bus_wdata = 32'h6;
        flt_valid = 1'b1; flt_type = 3'd2; flt_addr = 32'h3000_0000;
        @(negedge clk);
        bus_wr = 1'b0; flt_valid = 1'b0;
        rd_chk("R9 set beats clear", 6'd6, 32'h4);
        rd_chk("R9 capture on collision", 6'd10, 32'h3000_0000);

        // R9 fault beats disable write
        wr(6'd0, 32'h5);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'd0; bus_wdata = 32'h0;
        flt_valid = 1'b1; flt_type = 3'd3; flt_addr = 32'h4000_0000;
        @(negedge clk);
        bus_wr = 1'b0; flt_valid = 1'b0;
        check("R9 fault beats disable enable", 32'(xlat_enable), 1);
        check("R9 fault beats disable stall", 32'(xlat_stall), 1);
        rd_chk("R9 ctrl reads block", 6'd0, 7);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset irq", 32'(irq), 0);
        check("R1 reset stall", 32'(xlat_stall), 0);
        check("R1 reset cfg", cfg_out, 0);
        rd_chk("R1 reset ctrl", 6'd0, 0);
        rd_chk("R1 reset default capture", 6'd12, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule